// File: doc/BRIEF.md
# Serial Clock Pattern Generator

This block fills the parallel data words of a spare serializer lane so that the lane's serial output becomes a square-wave clock. The clock frequency is the lane bit rate divided by a programmable ratio of 10, 20, 30, 40 or 50. The ratio is the per-lane serial bit rate, taken after any oversampling, divided by the wanted clock frequency. For example, a 1.485 Gb/s lane carrying a 148.5 MHz clock needs ratio 10. A 270 Mb/s stream oversampled three times against a 27 MHz clock needs ratio 30. A 5.94 Gb/s lane against 148.5 MHz needs ratio 40.

Every cycle of the serializer's parallel clock, the block emits one 40-bit word, with bit 0 sent first. Each period of the waveform is ratio/2 ones followed by ratio/2 zeros. A phase counter carries the waveform position from one word to the next. Ratios that do not divide 40, such as 30 and 50, therefore run without a seam.

A single control register at byte offset 0x340 holds the ratio code and an enable bit. While the block is enabled, its lane takes over from the dedicated differential clock output, and the block drives low the enable of that dedicated output.

Top module: `clkPatGen`

## Requirements
- R1: After reset, `laneWord` is all zeros, `regRdata` is 0 and `dedClkEn` is 1.
- R2: A write with `regWe` high and `regAddr` equal to 0x340 stores bit 31 as the enable and bits [2:0] as the ratio code. The code values are 0=10, 1=20, 2=30, 3=40 and 4=50. From the next cycle on, `regRdata` reads back the enable in bit 31 and the code in bits [2:0], with all other bits 0.
- R3: A write to any other address leaves `regRdata` and the output waveform unchanged.
- R4: A write to 0x340 whose bits [2:0] hold 5, 6 or 7 keeps the previous ratio code. Its bit 31 still updates the enable.
- R5: The enable is set by a write at clock edge k. After edge k+1, the first word starts a period at phase 0. Bit i of a word is 1 exactly when ((p+i) mod ratio) < ratio/2, where p is the word's start phase.
- R6: The start phase of the next word is (p+40) mod ratio, so ratios 30 and 50 continue the waveform across word boundaries.
- R7: A new ratio code is applied only at the first word whose start phase is 0. Until then, the ratio in use is kept.
- R8: While the block is disabled, `laneWord` is all zeros one cycle later and the phase returns to 0. Re-enabling the block restarts the waveform at phase 0.
- R9: `dedClkEn` is the inverse of the stored enable bit and follows it one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serializer parallel clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 12 | Register byte address |
| regWdata | input | 32 | Register write data |
| regWe | input | 1 | Register write strobe |
| regRdata | output | 32 | Read-back of the control register |
| laneWord | output | 40 | Parallel word to the serializer, bit 0 sent first |
| dedClkEn | output | 1 | Enable for the dedicated clock output, low while the block is enabled |

## Verification
Ratios 10, 20 and 40 divide the word width, so every word repeats; these runs check bit order and duty cycle. Ratios 30 and 50 give a different start phase on each word; these runs separate a design that carries phase across words from one that restarts every word. Switching the ratio in the middle of a ratio-50 cycle, and again from 30 to 10, shows whether the switch waits for a phase-0 word. Writes with reserved codes and writes to other offsets are checked through the read-back, the dedicated-clock enable and the continued waveform.

// File: rtl/clkPatPkg.sv
package clkPatPkg;
  localparam int RATIO_W = 6;
  localparam int CODE_W  = 3;
  localparam logic [CODE_W-1:0] MAX_CODE = 3'd4;

  typedef struct packed {
    logic               enable;
    logic [RATIO_W-1:0] ratio;
  } dpCtrl_t;

  function automatic logic [RATIO_W-1:0] codeToRatio(input logic [CODE_W-1:0] code);
    return RATIO_W'((int'(code) + 1) * 10);
  endfunction
endpackage

// File: rtl/clkPatCtrl.sv
module clkPatCtrl
  import clkPatPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h340
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  output logic [DATA_W-1:0] regRdata,
  output dpCtrl_t           dpCtrl
);
  logic              enReg;
  logic [CODE_W-1:0] codeReg;
  logic              ctrlHit;
  logic              codeValid;
  logic              unusedWdata;

  assign ctrlHit     = regWe && (regAddr == CTRL_OFF);
  assign codeValid   = regWdata[CODE_W-1:0] <= MAX_CODE;
  assign unusedWdata = ^regWdata[DATA_W-2:CODE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      codeReg <= '0;
    end else if (ctrlHit) begin
      enReg <= regWdata[DATA_W-1];
      if (codeValid) codeReg <= regWdata[CODE_W-1:0];
    end
  end

  assign regRdata      = {enReg, {(DATA_W-CODE_W-1){1'b0}}, codeReg};
  assign dpCtrl.enable = enReg;
  assign dpCtrl.ratio  = codeToRatio(codeReg);
endmodule

// File: rtl/clkPatDatapath.sv
module clkPatDatapath
  import clkPatPkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            dpCtrl,
  output logic [WORD_W-1:0]  laneWord,
  output logic [RATIO_W-1:0] phase
);
  logic [RATIO_W-1:0] actRatio;
  logic [RATIO_W-1:0] useRatio;
  logic [RATIO_W-1:0] halfRatio;
  logic [RATIO_W-1:0] lastPhase;
  logic [RATIO_W-1:0] nextPhase;
  logic [WORD_W-1:0]  nextWord;

  // A new ratio is accepted only on a word that begins a period.
  assign useRatio  = (phase == '0) ? dpCtrl.ratio : actRatio;
  assign halfRatio = useRatio >> 1;
  assign lastPhase = useRatio - 1'b1;

  // Walk the phase bit by bit across the word; the final stage gives the next start phase.
  for (genvar i = 0; i < WORD_W; i++) begin : gBit
    logic [RATIO_W-1:0] phIn;
    logic [RATIO_W-1:0] phOut;
    if (i == 0) begin : gFirst
      assign phIn = phase;
    end else begin : gNext
      assign phIn = gBit[i-1].phOut;
    end
    assign nextWord[i] = phIn < halfRatio;
    assign phOut       = (phIn == lastPhase) ? '0 : phIn + 1'b1;
  end
  assign nextPhase = gBit[WORD_W-1].phOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneWord <= '0;
      phase    <= '0;
      actRatio <= codeToRatio('0);
    end else if (!dpCtrl.enable) begin
      laneWord <= '0;
      phase    <= '0;
    end else begin
      laneWord <= nextWord;
      phase    <= nextPhase;
      actRatio <= useRatio;
    end
  end
endmodule

// File: rtl/clkPatGen.sv
module clkPatGen
  import clkPatPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORD_W = 40,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h340
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  output logic [DATA_W-1:0] regRdata,
  output logic [WORD_W-1:0] laneWord,
  output logic              dedClkEn
);
  dpCtrl_t            dpCtrl;
  logic               ctrlEn;
  logic [RATIO_W-1:0] phase;

  clkPatCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_OFF(CTRL_OFF)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .dpCtrl(dpCtrl)
  );

  clkPatDatapath #(.WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .laneWord(laneWord), .phase(phase)
  );

  assign ctrlEn   = dpCtrl.enable;
  assign dedClkEn = !ctrlEn;
endmodule

// File: rtl/clkPatChk.sv
module clkPatChk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int WORD_W = 40,
  parameter int PH_W   = 6,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 12'h340
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regWe,
  input logic [DATA_W-1:0] regRdata,
  input logic [WORD_W-1:0] laneWord,
  input logic              dedClkEn,
  input logic              ctrlEn,
  input logic [PH_W-1:0]   phase
);
  AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr != CTRL_OFF) |=> $stable(regRdata)); // R3

  AST_BAD_CODE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == CTRL_OFF && regWdata[2:0] > 3'd4) |=> $stable(regRdata[2:0])); // R4

  AST_PERIOD_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && phase == '0) |=> laneWord[0]); // R5

  AST_HALF_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlEn && phase == '0 && (regRdata[2:0] == 3'd0 || regRdata[2:0] == 3'd1 ||
     regRdata[2:0] == 3'd3)) |=> ($countones(laneWord) == WORD_W / 2)); // R5

  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> (laneWord == '0)); // R8

  AST_DED_CLK_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == CTRL_OFF) |=> (dedClkEn == !$past(regWdata[DATA_W-1]))); // R9
endmodule

bind clkPatGen clkPatChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .PH_W(clkPatPkg::RATIO_W),
  .CTRL_OFF(CTRL_OFF)
) uChk (.*);

// File: tb/clkPatGen_test.sv
`timescale 1ns/1ps
module clkPatGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regWe = 1'b0;
  logic [31:0] regRdata;
  logic [39:0] laneWord;
  logic        dedClkEn;

  int    vectors = 0;
  int    miscompares = 0;
  string curReq = "R1";
  logic [39:0] expQ[$];

  // bench model state
  logic       sEn = 1'b0;
  logic [2:0] sCode = 3'd0;
  int         mPh = 0;
  int         mAct = 10;

  always #2 clk = ~clk;

  clkPatGen uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe),
    .regRdata(regRdata), .laneWord(laneWord), .dedClkEn(dedClkEn)
  );

  function automatic int ratioOf(input logic [2:0] c);
    return (int'(c) + 1) * 10;
  endfunction

  // driver-side model: pushes the word expected after each edge
  always @(posedge clk) begin
    if (rstN) begin
      logic [39:0] exp;
      int r;
      if (!sEn) begin
        exp = '0;
        mPh = 0;
      end else begin
        r = (mPh == 0) ? ratioOf(sCode) : mAct;
        mAct = r;
        for (int i = 0; i < 40; i++) exp[i] = ((mPh + i) % r) < (r / 2);
        mPh = (mPh + 40) % r;
      end
      expQ.push_back(exp);
      if (regWe && regAddr == 12'h340) begin
        sEn = regWdata[31];
        if (regWdata[2:0] <= 3'd4) sCode = regWdata[2:0];
      end
    end
  end

  // monitor: compares outputs away from the active edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      logic [39:0] e;
      logic [31:0] er;
      e = expQ.pop_front();
      er = {sEn, 28'b0, sCode};
      vectors++;
      if (laneWord !== e) begin
        miscompares++;
        $display("FAIL %s laneWord actual=%h expected=%h", curReq, laneWord, e);
      end
      vectors++;
      if (regRdata !== er) begin
        miscompares++;
        $display("FAIL %s regRdata actual=%h expected=%h", curReq, regRdata, er);
      end
      vectors++;
      if (dedClkEn !== !sEn) begin
        miscompares++;
        $display("FAIL %s dedClkEn actual=%b expected=%b", curReq, dedClkEn, !sEn);
      end
    end
  end

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic runCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in %s", curReq);
    finishRun();
  end

  initial begin
    // R1: reset state
    runCycles(3);
    vectors++;
    if (laneWord !== '0 || regRdata !== '0 || dedClkEn !== 1'b1) begin
      miscompares++;
      $display("FAIL R1 reset actual=%h/%h/%b expected=0/0/1", laneWord, regRdata, dedClkEn);
    end
    rstN = 1'b1;
    runCycles(2);

    curReq = "R5"; regWrite(12'h340, 32'h8000_0000); runCycles(8);
    curReq = "R8"; regWrite(12'h340, 32'h0000_0000); runCycles(3);
    curReq = "R5"; regWrite(12'h340, 32'h8000_0001); runCycles(6);
    curReq = "R9"; regWrite(12'h340, 32'h0000_0003); runCycles(2);
    curReq = "R5"; regWrite(12'h340, 32'h8000_0003); runCycles(4);
    curReq = "R6"; regWrite(12'h340, 32'h0000_0002); regWrite(12'h340, 32'h8000_0002); runCycles(12);
    curReq = "R6"; regWrite(12'h340, 32'h0000_0004); regWrite(12'h340, 32'h8000_0004); runCycles(12);
    curReq = "R7"; runCycles(2); regWrite(12'h340, 32'h8000_0002); runCycles(15);
    curReq = "R7"; runCycles(1); regWrite(12'h340, 32'h8000_0000); runCycles(10);
    curReq = "R8"; regWrite(12'h340, 32'h8000_0002); runCycles(1);
    regWrite(12'h340, 32'h0000_0002); runCycles(2);
    regWrite(12'h340, 32'h8000_0002); runCycles(8);
    curReq = "R4"; regWrite(12'h340, 32'h8000_0007); runCycles(5);
    curReq = "R4"; regWrite(12'h340, 32'h0000_0005); runCycles(3);
    curReq = "R3"; regWrite(12'h340, 32'h8000_0004); runCycles(2);
    regWrite(12'h344, 32'h8000_0003); regWrite(12'h000, 32'h0000_0000); runCycles(6);
    curReq = "R2"; regWrite(12'h340, 32'hFFFF_FFF9); runCycles(6);
    curReq = "R9"; regWrite(12'h340, 32'h7FFF_FFF8); runCycles(4);
    runCycles(2);
    finishRun();
  end
endmodule